// File: doc/BRIEF.md
# Prioritized Chip Select Decoder

This unit maps a 26-bit (64 MB) external bus address onto one of eight active-high chip select lines. Two 16-bit control words each hold four enable bits for each of four chip selects, one bit per memory block. The low control word serves blocks counted upward from address zero. The high control word serves mirrored blocks counted downward from the top of the space. Block sizes default to 2 MB, 2 MB, 4 MB and 8 MB and are set by parameters.

When several chip selects are enabled for the same block, a fixed priority chain picks one. A designated fallback select takes the block when both higher-ranked enables are clear. A peripheral I/O window at the top of the space, 4 KB by default, overrides every chip select and raises a separate peripheral select instead. Address-to-select decoding is purely combinational and is gated by an address-valid strobe. Control words are written as whole words on the clock edge and can be read back at any time.

Top module: `cs_prio_decoder`

## Requirements
- R1: After reset both control words read back as 16'h2C11. reg_sel_i = 0 selects the low word and 1 selects the high word.
- R2: With reg_we_i high at a rising clock edge, the word picked by reg_sel_i takes reg_wdata_i in full, and the other word is unchanged.
- R3: Low word layout: bits [3:0] enable cs 0, [7:4] cs 1, [11:8] cs 2 and [15:12] cs 3. Bit n of a nibble belongs to low block n. Low blocks 0 to 3 span 0x0000000-0x01FFFFF, 0x0200000-0x03FFFFF, 0x0400000-0x07FFFFF and 0x0800000-0x0FFFFFF.
- R4: High word layout: bits [3:0] enable cs 7, [7:4] cs 6, [11:8] cs 5 and [15:12] cs 4. Bit n of a nibble belongs to high block n. High blocks 0 to 3 span 0x3E00000-0x3FFFFFF, 0x3C00000-0x3DFFFFF, 0x3800000-0x3BFFFFF and 0x3000000-0x37FFFFF.
- R5: In a low block, cs 0 wins over cs 2, and cs 2 wins over cs 1.
- R6: In low block n, cs 1 is asserted whenever the cs 0 and cs 2 bits for n are both 0, whatever its own bit says. The cs 1 and cs 3 enable bits never change the outputs.
- R7: In a high block, cs 7 wins over cs 5, and cs 6 is asserted whenever both of those bits are 0. The cs 6 and cs 4 enable bits never change the outputs.
- R8: An address in 0x3FFF000-0x3FFFFFF with the strobe high raises periph_sel_o and holds all cs_o bits low.
- R9: With addr_valid_i low, every output is low. An address in 0x1000000-0x2FFFFFF matches no block, so no chip select is raised.
- R10: At most one bit of cs_o is high at any time.
- R11: The outputs follow the address combinationally. A control-word write changes the outputs only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Control word write enable |
| reg_sel_i | input | 1 | Control word select, 0 low, 1 high |
| reg_wdata_i | input | 16 | Control word write data |
| reg_rdata_o | output | 16 | Selected control word |
| addr_i | input | 26 | Bus address |
| addr_valid_i | input | 1 | Address strobe |
| cs_o | output | 8 | Chip selects, bit k is cs k |
| periph_sel_o | output | 1 | Peripheral I/O window select |

## Verification
Chip selects, the peripheral select and read data depend on the address and the stored words through logic alone. The bench therefore samples them one time unit after it changes the address, within the same clock low phase, and never across an edge. A control-word write lands on the following rising edge. Every write is driven on a falling edge and checked only after that rising edge has passed. The timing test also samples once before that edge, to confirm the old word still decides the output.

// File: rtl/cs_prio_pkg.sv
package cs_prio_pkg;
  localparam int ADDR_W  = 26;
  localparam int WORD_W  = 16;
  localparam int NUM_BLK = 4;
  localparam int BLK_W   = $clog2(NUM_BLK);
  localparam int NUM_CS  = 8;
  localparam int NIB_W   = WORD_W / 4;

  // block k spans [edge[k], edge[k+1]); one spare bit so a full-space edge fits
  localparam logic [NUM_BLK:0][ADDR_W:0] DEF_EDGE = {
    27'h1000000, 27'h0800000, 27'h0400000, 27'h0200000, 27'h0000000
  };

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_TOP  = 2'd1,
    SEL_MID  = 2'd2,
    SEL_FALL = 2'd3
  } win_e;
endpackage

// File: rtl/cs_ctrl_regs.sv
module cs_ctrl_regs #(
  parameter int                 WORD_W  = 16,
  parameter logic [WORD_W-1:0]  RST_VAL = 16'h2C11
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic                   sel_i,
  input  logic [WORD_W-1:0]      wdata_i,
  output logic [1:0][WORD_W-1:0] word_o
);
  logic [1:0][WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= {RST_VAL, RST_VAL};
    end else if (we_i) begin
      word_q[sel_i] <= wdata_i;
    end
  end

  assign word_o = word_q;

  assert_wr_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> word_q[$past(sel_i)] == $past(wdata_i));
  assert_wr_other_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> word_q[!$past(sel_i)] == $past(word_q[!sel_i]));
endmodule

// File: rtl/cs_blk_lookup.sv
module cs_blk_lookup #(
  parameter int ADDR_W  = 26,
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2,
  parameter logic [NUM_BLK:0][ADDR_W:0] EDGE = cs_prio_pkg::DEF_EDGE
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic [NUM_BLK-1:0] in_blk;
  logic [ADDR_W:0]    addr_x;

  assign addr_x = {1'b0, addr_i};

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_cmp
    assign in_blk[k] = (addr_x >= EDGE[k]) && (addr_x < EDGE[k+1]);
  end

  always_comb begin
    blk_o = '0;
    for (int k = 0; k < NUM_BLK; k++) begin
      if (in_blk[k]) blk_o = BLK_W'(k);
    end
  end

  assign hit_o = |in_blk;

  always_comb begin
    if (!$isunknown(addr_i)) begin
      assert_blk_single_R3: assert ($onehot0(in_blk));
    end
  end
endmodule

// File: rtl/cs_prio_resolve.sv
module cs_prio_resolve
  import cs_prio_pkg::*;
#(
  parameter int NUM_BLK = 4,
  parameter int BLK_W   = 2
) (
  input  logic               hit_i,
  input  logic [BLK_W-1:0]   blk_i,
  input  logic [NUM_BLK-1:0] top_en_i,
  input  logic [NUM_BLK-1:0] mid_en_i,
  output win_e               win_o
);
  // top > mid > fallback; fallback needs no enable of its own
  always_comb begin
    if (!hit_i)               win_o = SEL_NONE;
    else if (top_en_i[blk_i]) win_o = SEL_TOP;
    else if (mid_en_i[blk_i]) win_o = SEL_MID;
    else                      win_o = SEL_FALL;
  end

  always_comb begin
    if (!$isunknown({hit_i, blk_i, top_en_i, mid_en_i})) begin
      assert_hit_wins_R6: assert (hit_i == (win_o != SEL_NONE));
    end
  end
endmodule

// File: rtl/cs_prio_decoder.sv
module cs_prio_decoder
  import cs_prio_pkg::*;
#(
  parameter int ADDR_W  = cs_prio_pkg::ADDR_W,
  parameter int WORD_W  = cs_prio_pkg::WORD_W,
  parameter int NUM_BLK = cs_prio_pkg::NUM_BLK,
  parameter int NUM_CS  = cs_prio_pkg::NUM_CS,
  parameter logic [WORD_W-1:0]          RST_VAL  = 16'h2C11,
  parameter logic [NUM_BLK:0][ADDR_W:0] BLK_EDGE = cs_prio_pkg::DEF_EDGE,
  parameter logic [ADDR_W-1:0]          PER_BASE = 26'h3FFF000,
  parameter logic [ADDR_W-1:0]          PER_LAST = 26'h3FFFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_valid_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              periph_sel_o
);
  localparam int BLK_W = $clog2(NUM_BLK);
  localparam int NIB_W = WORD_W / 4;
  // per group: cs index for top, mid and fallback winners
  localparam int TOP_CS  [2] = '{0, 7};
  localparam int MID_CS  [2] = '{2, 5};
  localparam int FALL_CS [2] = '{1, 6};

  logic [1:0][WORD_W-1:0] word;
  logic [1:0]             grp_hit;
  win_e                   grp_win [2];
  logic [1:0][NUM_CS-1:0] grp_cs;
  logic                   per_hit;

  cs_ctrl_regs #(.WORD_W(WORD_W), .RST_VAL(RST_VAL)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .word_o  (word)
  );

  assign reg_rdata_o = word[reg_sel_i];

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic [ADDR_W-1:0] lk_addr;
    logic [BLK_W-1:0]  blk;

    // high group counts down from the top: mirror the address
    assign lk_addr = (g == 0) ? addr_i : ~addr_i;

    cs_blk_lookup #(
      .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_W(BLK_W), .EDGE(BLK_EDGE)
    ) u_lookup (
      .addr_i (lk_addr),
      .hit_o  (grp_hit[g]),
      .blk_o  (blk)
    );

    cs_prio_resolve #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_resolve (
      .hit_i    (grp_hit[g]),
      .blk_i    (blk),
      .top_en_i (word[g][NUM_BLK-1:0]),
      .mid_en_i (word[g][2*NIB_W +: NUM_BLK]),
      .win_o    (grp_win[g])
    );

    always_comb begin
      grp_cs[g] = '0;
      unique case (grp_win[g])
        SEL_TOP:  grp_cs[g][TOP_CS[g]]  = 1'b1;
        SEL_MID:  grp_cs[g][MID_CS[g]]  = 1'b1;
        SEL_FALL: grp_cs[g][FALL_CS[g]] = 1'b1;
        default:  grp_cs[g] = '0;
      endcase
    end
  end

  assign per_hit      = (addr_i >= PER_BASE) && (addr_i <= PER_LAST);
  assign periph_sel_o = addr_valid_i && per_hit;
  assign cs_o         = (addr_valid_i && !per_hit) ? (grp_cs[0] | grp_cs[1]) : '0;

  assert_cs_onehot0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  assert_grp_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_hit[0] && grp_hit[1]));
  assert_periph_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    periph_sel_o |-> cs_o == '0);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |-> (cs_o == '0) && !periph_sel_o);
  assert_lo_cs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && grp_hit[0]) |-> $countones(cs_o[3:0]) == 1);
  assert_hi_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && grp_hit[1] && !per_hit) |-> $countones(cs_o[7:4]) == 1);
endmodule

// File: tb/cs_prio_decoder_bench.sv
module cs_prio_decoder_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [25:0] addr;
    logic [15:0] ra;
    logic [15:0] rb;
    logic [7:0]  cs;
    logic        per;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{26'h0000000, 16'h2C11, 16'h2C11, 8'h01, 1'b0, 8'd3},  // R3 low blk0 -> cs0
    '{26'h0200000, 16'h2C11, 16'h2C11, 8'h02, 1'b0, 8'd6},  // R6 blk1 fallback
    '{26'h0400000, 16'h2C11, 16'h2C11, 8'h04, 1'b0, 8'd3},
    '{26'h0FFFFFF, 16'h2C11, 16'h2C11, 8'h04, 1'b0, 8'd3},
    '{26'h1000000, 16'h2C11, 16'h2C11, 8'h00, 1'b0, 8'd9},  // R9 gap
    '{26'h2FFFFFF, 16'h2C11, 16'h2C11, 8'h00, 1'b0, 8'd9},
    '{26'h3000000, 16'h2C11, 16'h2C11, 8'h20, 1'b0, 8'd4},  // R4 high blk3
    '{26'h3800000, 16'h2C11, 16'h2C11, 8'h20, 1'b0, 8'd4},
    '{26'h3C00000, 16'h2C11, 16'h2C11, 8'h40, 1'b0, 8'd7},  // R7 fallback
    '{26'h3E00000, 16'h2C11, 16'h2C11, 8'h80, 1'b0, 8'd4},
    '{26'h3FFF000, 16'h2C11, 16'h2C11, 8'h00, 1'b1, 8'd8},  // R8 window
    '{26'h3FFEFFF, 16'h2C11, 16'h2C11, 8'h80, 1'b0, 8'd8},
    '{26'h0000000, 16'hF0F0, 16'h2C11, 8'h02, 1'b0, 8'd6},  // R6 cs3 bits ignored
    '{26'h0000000, 16'hF000, 16'h2C11, 8'h02, 1'b0, 8'd6},
    '{26'h0800000, 16'h0F0F, 16'h2C11, 8'h01, 1'b0, 8'd5},  // R5 cs0 over cs2
    '{26'h0800000, 16'h0F00, 16'h2C11, 8'h04, 1'b0, 8'd5},
    '{26'h0800000, 16'h0008, 16'h2C11, 8'h01, 1'b0, 8'd3},
    '{26'h0400000, 16'h0008, 16'h2C11, 8'h02, 1'b0, 8'd3},
    '{26'h3E00000, 16'h2C11, 16'hF0F0, 8'h40, 1'b0, 8'd7},  // R7 cs4/cs6 bits ignored
    '{26'h3000000, 16'h2C11, 16'h0F0F, 8'h80, 1'b0, 8'd7},
    '{26'h3000000, 16'h2C11, 16'h0F00, 8'h20, 1'b0, 8'd7},
    '{26'h3C00000, 16'h2C11, 16'hF000, 8'h40, 1'b0, 8'd7},
    '{26'h3FFFFFF, 16'h2C11, 16'h0001, 8'h00, 1'b1, 8'd8}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [25:0] addr = '0;
  logic        valid = 1'b0;
  logic [7:0]  cs;
  logic        per;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_prio_decoder u_cs_prio_decoder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_we_i     (we),
    .reg_sel_i    (sel),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .addr_i       (addr),
    .addr_valid_i (valid),
    .cs_o         (cs),
    .periph_sel_o (per)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [15:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rdata;
  endtask

  initial begin
    logic [15:0] r;
    #(CLK_PERIOD*2 + 2) rst_n = 1'b1;
    // R1 reset values
    rd(1'b0, r); chk("R1", r, 16'h2C11);
    rd(1'b1, r); chk("R1", r, 16'h2C11);
    // R2 write and isolation
    wr(1'b1, 16'h1234);
    rd(1'b1, r); chk("R2", r, 16'h1234);
    rd(1'b0, r); chk("R2", r, 16'h2C11);
    wr(1'b0, 16'hA5C3);
    rd(1'b0, r); chk("R2", r, 16'hA5C3);
    rd(1'b1, r); chk("R2", r, 16'h1234);

    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i].ra);
      wr(1'b1, VEC[i].rb);
      @(negedge clk);
      addr = VEC[i].addr; valid = 1'b1;
      #1;
      n_chk++;
      if (cs !== VEC[i].cs || per !== VEC[i].per) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual=%h/%b expected=%h/%b",
                 VEC[i].req, i, cs, per, VEC[i].cs, VEC[i].per);
      end
      chk("R10", 32'($countones(cs) <= 1), 32'd1);
    end

    // R9 strobe low silences everything
    wr(1'b0, 16'h2C11); wr(1'b1, 16'h2C11);
    @(negedge clk); addr = 26'h0000000; valid = 1'b0;
    #1 chk("R9", {cs, per}, 9'h0);
    addr = 26'h3FFF800;
    #1 chk("R9", {cs, per}, 9'h0);

    // R11 combinational address path, registered write path
    valid = 1'b1; addr = 26'h0000000;
    #1 chk("R11", cs, 8'h01);
    addr = 26'h3E00000;
    #1 chk("R11", cs, 8'h80);
    @(negedge clk);
    addr = 26'h0000000; we = 1'b1; sel = 1'b0; wdata = 16'h0000;
    #1 chk("R11", cs, 8'h01);          // old word still decides before the edge
    @(negedge clk); we = 1'b0;
    #1 chk("R11", cs, 8'h02);          // R6 fallback after the edge

    // R6 cs1 bits set alone do not move the winner away from cs2
    wr(1'b0, 16'h04F0);
    @(negedge clk); addr = 26'h0400000;
    #1 chk("R6", cs, 8'h04);

    // R1 reset again restores the words
    @(negedge clk); rst_n = 1'b0;
    #1 rst_n = 1'b1;
    rd(1'b0, r); chk("R1", r, 16'h2C11);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule